// File: doc/BRIEF.md
# Dark-Column Black Level Estimator

This block sits on the digitized pixel stream of an image sensor readout, one pixel per valid cycle, with a marker on the first pixel of each line. It counts columns from that marker and sorts every pixel into a class. The classes are the uncharged lead-in positions, the shielded reference columns, the two shielded edge columns that leak light, the image columns and the shielded columns at the end of the line.

The inner shielded columns are summed on every line. The sum is scaled by a fixed-point reciprocal to give the line's black level. The level is written into a running register, either directly or through a first-order IIR step whose weight is set by a shift input. The level is ready before the first image column arrives. Image pixels of the same line are therefore corrected without being held back: the black level is subtracted and the result is floored at zero. Every other pixel passes through unchanged. Each output pixel carries a one-hot class flag, and the current black level is always visible.

Top module: `blackLevelEst`

## Requirements
- R1: While reset is held, and after it until the first valid pixel comes out, `pixOutValid`, `pixOut`, `classFlags` and `blackLevel` are all zero.
- R2: The column index is 0 on a valid pixel with `lineStart` high. Otherwise it is one more than the index of the previous valid pixel, saturating at 1644. After reset and before any `lineStart` the index is 1644. The default class map is: columns 0..3 are lead-in (`classFlags` bit 0), columns 4 and 19 are edge guards (bit 1), columns 5..18 are reference (bit 2), columns 20..1627 are image (bit 3) and columns 1628..1643 are trailing shield (bit 4). Index 1644 gives all flags zero. At most one flag is set.
- R3: Edge guard pixels (columns 4 and 19) have no effect on the black level.
- R4: The line estimate is m = (S*4681 + 32768) >> 16, where S is the sum of the 14 reference pixels of the line (4681 = round(65536/14)).
- R5: The black level register is updated when the column-19 pixel is accepted. The output of that pixel already shows the new level, and the same line's image pixels are corrected with it.
- R6: An image-column output equals the input pixel minus `blackLevel`, or zero when that difference is negative.
- R7: Lead-in, guard and reference pixels, and pixels at index 1644, are output unchanged.
- R8: Trailing shield pixels are flagged with bit 4, output unchanged, and have no effect on the black level.
- R9: At the update the new level is L + ((m - L) >>> k), with signed arithmetic shift, where L is the old level and k is `iirShift`. With k = 0 the level becomes m.
- R10: A line that is restarted by `lineStart` before column 19 leaves the black level unchanged.
- R11: Each valid input yields exactly one valid output on the next clock edge, in order. Cycles with `pixValid` low produce no output and do not advance the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixIn | input | 12 | Input pixel sample |
| pixValid | input | 1 | Input pixel valid |
| lineStart | input | 1 | Marks the first pixel of a line (with pixValid) |
| iirShift | input | 3 | IIR weight shift k; 0 bypasses filtering |
| pixOut | output | 12 | Corrected or passed-through pixel |
| pixOutValid | output | 1 | Output pixel valid |
| blackLevel | output | 12 | Current black level |
| classFlags | output | 5 | One-hot pixel class of the output pixel |

## Verification
The bench drives edge guard pixels to full scale and to zero on different lines. A design that averaged all 16 shielded columns would show a black level shifted by hundreds of codes. Image pixels smaller than the level are sent to catch a subtraction that wraps instead of flooring at zero. The first image column is checked against the level of its own line, which exposes a design that applies the estimate one line late. Further stimulus covers lines cut off before the last guard column, IIR steps both up and down, and gaps in the valid strobe. These catch a design that updates on partial data, rounds the signed step wrongly, or counts idle cycles as columns.

// File: rtl/blackLevelPkg.sv
package blackLevelPkg;
  localparam int NUM_CLASS = 5;
  localparam int CLS_EMPTY = 0;
  localparam int CLS_GUARD = 1;
  localparam int CLS_REF = 2;
  localparam int CLS_ACTIVE = 3;
  localparam int CLS_TAIL = 4;

  typedef struct packed {
    logic pixel;   // a pixel is accepted this cycle
    logic clrSum;  // restart reference accumulation
    logic accum;   // add this pixel to the reference sum
    logic update;  // fold the line estimate into the level
  } ctlStrobes_t;
endpackage

// File: rtl/blackLevelCtl.sv
module blackLevelCtl
  import blackLevelPkg::*;
#(
  parameter int EMPTY_N  = 4,
  parameter int DARK_N   = 16,
  parameter int ACTIVE_N = 1608,
  parameter int TAIL_N   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pixValid,
  input  logic                 lineStart,
  output ctlStrobes_t          strb,
  output logic [NUM_CLASS-1:0] flags
);
  localparam int TOTAL    = EMPTY_N + DARK_N + ACTIVE_N + TAIL_N;
  localparam int COL_W    = $clog2(TOTAL + 1);
  localparam int GUARD_LO = EMPTY_N;
  localparam int GUARD_HI = EMPTY_N + DARK_N - 1;
  localparam int ACT_LO   = EMPTY_N + DARK_N;
  localparam int TAIL_LO  = ACT_LO + ACTIVE_N;

  logic [COL_W-1:0] colCnt;
  logic [COL_W-1:0] col;

  assign col = lineStart ? '0 : colCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt <= COL_W'(TOTAL);
    end else if (pixValid) begin
      colCnt <= (col == COL_W'(TOTAL)) ? col : col + 1'b1;
    end
  end

  always_comb begin
    flags = '0;
    flags[CLS_EMPTY]  = col < COL_W'(GUARD_LO);
    flags[CLS_GUARD]  = (col == COL_W'(GUARD_LO)) || (col == COL_W'(GUARD_HI));
    flags[CLS_REF]    = (col > COL_W'(GUARD_LO)) && (col < COL_W'(GUARD_HI));
    flags[CLS_ACTIVE] = (col >= COL_W'(ACT_LO)) && (col < COL_W'(TAIL_LO));
    flags[CLS_TAIL]   = (col >= COL_W'(TAIL_LO)) && (col < COL_W'(TOTAL));
  end

  always_comb begin
    strb.pixel  = pixValid;
    strb.clrSum = pixValid && lineStart;
    strb.accum  = pixValid && flags[CLS_REF];
    strb.update = pixValid && (col == COL_W'(GUARD_HI));
  end
endmodule

// File: rtl/blackLevelDp.sv
module blackLevelDp
  import blackLevelPkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int REF_N   = 14,
  parameter int SHIFT_W = 3,
  parameter int FRAC    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic [NUM_CLASS-1:0] flags,
  input  logic [PIX_W-1:0]     pixIn,
  input  logic [SHIFT_W-1:0]   iirShift,
  output logic [PIX_W-1:0]     pixOut,
  output logic                 pixOutValid,
  output logic [PIX_W-1:0]     blackLevel,
  output logic [NUM_CLASS-1:0] classFlags
);
  localparam int SUM_W  = PIX_W + $clog2(REF_N + 1);
  localparam int RECIP  = ((1 << FRAC) + REF_N / 2) / REF_N;
  localparam int PROD_W = SUM_W + FRAC + 1;

  logic [SUM_W-1:0]        refSum;
  logic [PIX_W-1:0]        level;
  logic [PROD_W-1:0]       scaled;
  logic [PIX_W-1:0]        lineMean;
  logic signed [PIX_W+1:0] diff;
  logic signed [PIX_W+1:0] step;
  logic signed [PIX_W+1:0] nextLevel;
  logic [PIX_W:0]          corrected;

  always_comb begin
    scaled    = PROD_W'(refSum) * PROD_W'(RECIP) + PROD_W'(1 << (FRAC - 1));
    lineMean  = PIX_W'(scaled >> FRAC);
    diff      = $signed({2'b00, lineMean}) - $signed({2'b00, level});
    step      = diff >>> iirShift;
    nextLevel = $signed({2'b00, level}) + step;
    corrected = {1'b0, pixIn} - {1'b0, level};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refSum <= '0;
      level  <= '0;
    end else begin
      if (strb.clrSum)      refSum <= '0;
      else if (strb.accum)  refSum <= refSum + SUM_W'(pixIn);
      if (strb.update)      level  <= PIX_W'(nextLevel);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOutValid <= 1'b0;
      pixOut      <= '0;
      classFlags  <= '0;
    end else begin
      pixOutValid <= strb.pixel;
      classFlags  <= strb.pixel ? flags : '0;
      if (strb.pixel) begin
        if (flags[CLS_ACTIVE]) pixOut <= corrected[PIX_W] ? '0 : corrected[PIX_W-1:0];
        else                   pixOut <= pixIn;
      end
    end
  end

  assign blackLevel = level;
endmodule

// File: rtl/blackLevelEst.sv
module blackLevelEst
  import blackLevelPkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int EMPTY_N  = 4,
  parameter int DARK_N   = 16,
  parameter int ACTIVE_N = 1608,
  parameter int TAIL_N   = 16,
  parameter int SHIFT_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIX_W-1:0]     pixIn,
  input  logic                 pixValid,
  input  logic                 lineStart,
  input  logic [SHIFT_W-1:0]   iirShift,
  output logic [PIX_W-1:0]     pixOut,
  output logic                 pixOutValid,
  output logic [PIX_W-1:0]     blackLevel,
  output logic [NUM_CLASS-1:0] classFlags
);
  localparam int REF_N = DARK_N - 2;

  ctlStrobes_t          strb;
  logic [NUM_CLASS-1:0] flags;

  blackLevelCtl #(
    .EMPTY_N(EMPTY_N), .DARK_N(DARK_N), .ACTIVE_N(ACTIVE_N), .TAIL_N(TAIL_N)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart),
    .strb(strb), .flags(flags)
  );

  blackLevelDp #(
    .PIX_W(PIX_W), .REF_N(REF_N), .SHIFT_W(SHIFT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .flags(flags), .pixIn(pixIn),
    .iirShift(iirShift), .pixOut(pixOut), .pixOutValid(pixOutValid),
    .blackLevel(blackLevel), .classFlags(classFlags)
  );
endmodule

// File: rtl/blackLevelChk.sv
module blackLevelChk #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [PIX_W-1:0] pixIn,
  input logic             pixValid,
  input logic [PIX_W-1:0] pixOut,
  input logic             pixOutValid,
  input logic [PIX_W-1:0] blackLevel,
  input logic [4:0]       classFlags
);
  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(classFlags)); // R2
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !pixOutValid |-> classFlags == '0); // R2
  AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pixValid) |-> $stable(blackLevel)); // R5
  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rstN)
    pixOutValid |-> $past(pixValid)); // R11
  AST_IN_GIVES_OUT: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> pixOutValid); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pixOutValid && classFlags[3] |-> pixOut <= $past(pixIn)); // R6
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    pixOutValid && !classFlags[3] |-> pixOut == $past(pixIn)); // R7
endmodule

bind blackLevelEst blackLevelChk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .pixIn(pixIn), .pixValid(pixValid), .pixOut(pixOut),
  .pixOutValid(pixOutValid), .blackLevel(blackLevel), .classFlags(classFlags)
);

// File: tb/test_blackLevelEst.sv
module test_blackLevelEst;
  localparam int TOTAL = 1644;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] pixIn = '0;
  logic pixValid = 1'b0;
  logic lineStart = 1'b0;
  logic [2:0] iirShift = '0;
  logic [11:0] pixOut;
  logic pixOutValid;
  logic [11:0] blackLevel;
  logic [4:0] classFlags;

  always #10 clk = ~clk;

  blackLevelEst i_blackLevelEst (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .pixValid(pixValid), .lineStart(lineStart),
    .iirShift(iirShift), .pixOut(pixOut), .pixOutValid(pixOutValid),
    .blackLevel(blackLevel), .classFlags(classFlags)
  );

  typedef struct { int pix; int flags; int level; int tag; } exp_t;
  exp_t q[$];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int mCol = TOTAL;
  int mSum = 0;
  int mLevel = 0;

  function automatic string tagName(int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(bit ok, int tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tagName(tag), what, act, exp);
    end
  endtask

  // Class map per R2: bit0 lead-in, bit1 guard, bit2 reference, bit3 image, bit4 trailing
  function automatic int flagsOf(int col);
    if (col < 4) return 1;
    if (col == 4 || col == 19) return 2;
    if (col < 19) return 4;
    if (col < 1628) return 8;
    if (col < TOTAL) return 16;
    return 0;
  endfunction

  // Driver: applies one pixel and pushes the expected result
  task automatic sendPix(int pix, bit ls, int updTag);
    int col, fl, expPix, tag, mean, diff;
    @(posedge clk); #2;
    pixIn = 12'(pix); pixValid = 1'b1; lineStart = ls;
    col = ls ? 0 : mCol;
    fl = flagsOf(col);
    if (ls) mSum = 0;
    if (fl == 8) expPix = (pix > mLevel) ? pix - mLevel : 0;
    else expPix = pix;
    case (fl)
      1: tag = 7; 2: tag = 3; 4: tag = 4; 8: tag = 6; 16: tag = 8; default: tag = 2;
    endcase
    if (fl == 4) mSum += pix;
    if (col == 19) begin
      mean = (mSum * (((1 << 16) + 7) / 14) + 32768) >>> 16;   // R4
      diff = mean - mLevel;
      mLevel = mLevel + (diff >>> int'(iirShift));             // R9
      tag = updTag;                                            // R5 or R9
    end
    q.push_back('{expPix, fl, mLevel, tag});
    mCol = (col == TOTAL) ? col : col + 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      pixValid = 1'b0; lineStart = 1'b0; pixIn = 12'hABC;
    end
  endtask

  function automatic int pixFor(int col, int refBase, int guardVal, int seed);
    int fl = flagsOf(col);
    if (fl == 1) return 9;
    if (fl == 2) return guardVal;
    if (fl == 4) return refBase + ((col * seed) % 5);
    if (fl == 8) return (col * seed * 13) % 4096;
    if (fl == 16) return 4000 + (col % 50);
    return 55;
  endfunction

  task automatic sendLine(int len, int refBase, int guardVal, int seed, int gapEvery, int updTag);
    for (int c = 0; c < len; c++) begin
      sendPix(pixFor(c, refBase, guardVal, seed), c == 0, updTag);
      if (gapEvery != 0 && (c % gapEvery) == gapEvery - 1) idle(2);
    end
  endtask

  // Monitor: pops and compares every produced pixel (R11 ordering and latency)
  always @(negedge clk) begin
    if (rstN && pixOutValid) begin
      if (q.size() == 0) begin
        check(0, 11, "unexpected output", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(int'(pixOut) == e.pix, e.tag, "pixOut", int'(pixOut), e.pix);
        check(int'(classFlags) == e.flags, 2, "classFlags", int'(classFlags), e.flags);
        check(int'(blackLevel) == e.level, e.tag, "blackLevel", int'(blackLevel), e.level);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(pixOutValid == 0 && pixOut == 0, 1, "reset outputs", int'(pixOut), 0);
    check(blackLevel == 0 && classFlags == 0, 1, "reset level/flags", int'(blackLevel), 0);
    @(posedge clk); #2; rstN = 1'b1;
    idle(2);
    @(negedge clk);
    check(pixOutValid == 0 && blackLevel == 0, 1, "after reset", int'(blackLevel), 0);

    // R2: pixels before the first line marker have no class and pass unchanged
    sendPix(300, 0, 5); sendPix(301, 0, 5); sendPix(302, 0, 5);
    idle(2);

    // R3 R4 R5 R6 R8: full line, guards at full scale, direct update
    iirShift = 3'd0;
    sendLine(TOTAL + 2, 100, 4095, 3, 0, 5);
    idle(3);
    // R3: guards at zero must give the same estimate source; other references
    sendLine(TOTAL, 203, 0, 7, 97, 5);
    idle(3);
    @(negedge clk);
    check(int'(blackLevel) == mLevel, 3, "level after zero-guard line", int'(blackLevel), mLevel);

    // R9: IIR steps up then down with shift 2
    iirShift = 3'd2;
    sendLine(40, 1000, 4095, 11, 0, 9);
    idle(2);
    sendLine(40, 0, 4095, 13, 0, 9);
    idle(2);
    iirShift = 3'd1;
    sendLine(40, 2, 17, 5, 7, 9);
    idle(2);

    // R10: line cut before column 19 leaves the level unchanged
    iirShift = 3'd0;
    sendLine(19, 3000, 3000, 2, 0, 10);
    idle(3);
    @(negedge clk);
    check(int'(blackLevel) == mLevel, 10, "level after cut line", int'(blackLevel), mLevel);
    sendLine(60, 4000, 0, 9, 0, 5);
    idle(4);

    @(negedge clk);
    check(q.size() == 0, 11, "outstanding expected items", q.size(), 0);
    finish();
  end
endmodule